// File: doc/BRIEF.md
# Wide-Path Lane Controller for a Multiplexed Address/Data Bus

This block sits on the master side of a multiplexed address/data bus. The bus has a 32-bit base path and an optional 32-bit upper extension. While reset is held, the block samples a sense line to learn whether the upper extension is wired to the slot. That choice then stays fixed until the next reset.

For each single-word transaction the block decides whether to ask for the wide path. Only memory-type commands in a wide-capable slot may ask for it. The block then sends the address and the data:

- **Address.** A wide transaction sends the address on both lane groups. A narrow transaction whose address has nonzero upper bits sends it as a low-half/high-half dual-address pair.
- **Data.** When the target acknowledges the width request, the 64-bit data word goes out in one phase. Otherwise it goes out as two 32-bit phases, low half first.

The block produces even parity for the upper lanes one clock after the lanes it covers, together with an enable that marks when the parity bit is driven. All bus control lines are active-low.

Top module: `wide_lane_ctl`

## Requirements
- R1: The slot is wide-capable if and only if `wide_sense_n` was low at the last rising clock edge with `rst_n` low. In a slot that is not wide-capable, `wreq_n` stays high and `ad_hi_oe` stays low for every transaction.
- R2: `wreq_n` goes low only for memory commands, codes 0x6, 0x7, 0xC, 0xE and 0xF, and only in a wide-capable slot. For any other command it stays high.
- R3: In a data phase, the upper lanes are driven (`ad_hi_oe` = 1) only when `wreq_n` is low and `wack_n` is low in that same cycle.
- R4: In a data phase where both lane groups are driven:
  - `ad_lo` carries data bits 31:0 and `cbe_lo_n` carries the inverse of byte enables 3:0.
  - `ad_hi` carries data bits 63:32 and `cbe_hi_n` carries the inverse of byte enables 7:4.
- R5: When the upper lanes are not used for data, the word goes out as two consecutive data phases on the low lanes:
  - first data bits 31:0 with the inverse of byte enables 3:0;
  - then data bits 63:32 with the inverse of byte enables 7:4.
- R6: A wide transaction has a single address phase:
  - `ad_lo` carries address bits 31:0, `ad_hi` carries address bits 63:32, and `cbe_hi_n` carries the inverse of the command.
  - `cbe_lo_n` carries the inverse of the dual-address code 0xD when address bits 63:32 are nonzero, and the inverse of the command otherwise.
- R7: A narrow transaction whose address bits 63:32 are nonzero uses two address phases:
  - first address bits 31:0 with the inverse of code 0xD on `cbe_lo_n`;
  - then address bits 63:32 with the inverse of the command.
  With zero upper address bits it uses one address phase carrying the inverse of the command.
- R8: `par_hi_oe` equals the previous cycle's `ad_hi_oe`. When it is high, `par_hi` is the XOR of all bits of `ad_hi` and `cbe_hi_n` of the previous cycle (even parity).
- R9: The following timing holds around `xfer_go`:
  - An `xfer_go` seen while idle starts a transaction whose first address phase appears in the next cycle.
  - `xfer_busy` is high from that cycle through the last data phase.
  - An `xfer_go` seen while busy is ignored.
- R10: While idle:
  - `ad_lo` and `ad_hi` are zero, and `ad_hi_oe` is low.
  - `cbe_lo_n` and `cbe_hi_n` are all ones, and `wreq_n` is high.
  - `addr_phase` and `data_phase` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wide_sense_n | input | 1 | Width-capability sense, sampled while reset is held |
| xfer_go | input | 1 | Start a transaction with the fields below |
| xfer_cmd | input | 4 | Bus command code |
| xfer_addr | input | 64 | Transaction address |
| xfer_data | input | 64 | Transaction data word |
| xfer_be | input | 8 | Byte enables, active high |
| xfer_busy | output | 1 | Transaction in progress |
| wack_n | input | 1 | Target width acknowledge, active low |
| wreq_n | output | 1 | Width request, active low |
| addr_phase | output | 1 | Current cycle is an address phase |
| data_phase | output | 1 | Current cycle is a data phase |
| ad_lo | output | 32 | Low address/data lanes |
| ad_hi | output | 32 | Upper address/data lanes |
| ad_hi_oe | output | 1 | Upper lanes driven |
| cbe_lo_n | output | 4 | Low command/byte-enable lines, active low |
| cbe_hi_n | output | 4 | Upper command/byte-enable lines, active low |
| par_hi | output | 1 | Even parity for the previous cycle's upper lanes |
| par_hi_oe | output | 1 | Upper parity driven |

## Verification
The phase timing is fixed:
- The first address phase appears one cycle after `xfer_go` is registered.
- A second address phase, if there is one, follows in the next cycle, and then come one or two data phases.
- The parity bit and its enable lag the upper lanes by exactly one further cycle.

The bench drives inputs on falling edges and compares every cycle of a transaction at the falling edge against a per-cycle reference sequence built from the requirements. It also carries the expected parity and enable forward one cycle to compare with the lagged outputs. Because `wack_n` reaches the upper-lane enable without a register, the bench holds it steady for a whole scenario.

// File: rtl/wide_lane_ctl.sv
module wide_lane_ctl #(
  parameter int LW = 32,
  localparam int BW = LW / 8,
  parameter logic [BW-1:0] DAC_CMD = 4'b1101
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_sense_n,
  input  logic            xfer_go,
  input  logic [BW-1:0]   xfer_cmd,
  input  logic [2*LW-1:0] xfer_addr,
  input  logic [2*LW-1:0] xfer_data,
  input  logic [2*BW-1:0] xfer_be,
  output logic            xfer_busy,
  input  logic            wack_n,
  output logic            wreq_n,
  output logic            addr_phase,
  output logic            data_phase,
  output logic [LW-1:0]   ad_lo,
  output logic [LW-1:0]   ad_hi,
  output logic            ad_hi_oe,
  output logic [BW-1:0]   cbe_lo_n,
  output logic [BW-1:0]   cbe_hi_n,
  output logic            par_hi,
  output logic            par_hi_oe
);

  typedef enum logic [2:0] {S_IDLE, S_A1, S_A2, S_D1, S_D2} st_t;

  st_t              st;
  logic             wide_slot, wide_q;
  logic [BW-1:0]    cmd_q;
  logic [2*LW-1:0]  addr_q, data_q;
  logic [2*BW-1:0]  be_q;

  function automatic logic mem_cmd(input logic [BW-1:0] c);
    return c == 4'h6 || c == 4'h7 || c == 4'hC || c == 4'hE || c == 4'hF;
  endfunction

  wire wack  = ~wack_n;
  wire hi_nz = |addr_q[2*LW-1:LW];
  wire both  = wide_q & wack;

  always_ff @(posedge clk)
    if (!rst_n) wide_slot <= ~wide_sense_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wide_q <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (xfer_go) begin
          st     <= S_A1;
          wide_q <= wide_slot & mem_cmd(xfer_cmd);
          cmd_q  <= xfer_cmd;
          addr_q <= xfer_addr;
          data_q <= xfer_data;
          be_q   <= xfer_be;
        end
        S_A1:    st <= (!wide_q && hi_nz) ? S_A2 : S_D1;
        S_A2:    st <= S_D1;
        S_D1:    st <= both ? S_IDLE : S_D2;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign xfer_busy  = st != S_IDLE;
  assign addr_phase = st == S_A1 || st == S_A2;
  assign data_phase = st == S_D1 || st == S_D2;

  always_comb begin
    ad_lo    = '0;
    ad_hi    = '0;
    ad_hi_oe = 1'b0;
    cbe_lo_n = '1;
    cbe_hi_n = '1;
    wreq_n   = 1'b1;
    case (st)
      S_A1: begin
        ad_lo    = addr_q[LW-1:0];
        cbe_lo_n = hi_nz ? ~DAC_CMD : ~cmd_q;
        wreq_n   = ~wide_q;
        if (wide_q) begin
          ad_hi    = addr_q[2*LW-1:LW];
          ad_hi_oe = 1'b1;
          cbe_hi_n = ~cmd_q;
        end
      end
      S_A2: begin
        ad_lo    = addr_q[2*LW-1:LW];
        cbe_lo_n = ~cmd_q;
      end
      S_D1: begin
        ad_lo    = data_q[LW-1:0];
        cbe_lo_n = ~be_q[BW-1:0];
        wreq_n   = ~wide_q;
        if (both) begin
          ad_hi    = data_q[2*LW-1:LW];
          ad_hi_oe = 1'b1;
          cbe_hi_n = ~be_q[2*BW-1:BW];
        end
      end
      S_D2: begin
        ad_lo    = data_q[2*LW-1:LW];
        cbe_lo_n = ~be_q[2*BW-1:BW];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_hi    <= 1'b0;
      par_hi_oe <= 1'b0;
    end else begin
      par_hi    <= ^{ad_hi, cbe_hi_n};
      par_hi_oe <= ad_hi_oe;
    end
  end

  assert_narrow_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_slot |-> (wreq_n && !ad_hi_oe));

  assert_mem_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wreq_n |-> mem_cmd(cmd_q));

  assert_hi_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && ad_hi_oe) |-> (!wreq_n && !wack_n));

  assert_split_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && !ad_hi_oe && !wreq_n) |=> (data_phase && cbe_lo_n == ~$past(be_q[2*BW-1:BW])));

  assert_dac_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !ad_hi_oe && cbe_lo_n == ~DAC_CMD) |=> (addr_phase && ad_lo == $past(addr_q[2*LW-1:LW])));

  assert_par_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ad_hi_oe |=> par_hi_oe);

  assert_par_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_hi_oe |=> !par_hi_oe);

  assert_go_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && xfer_busy) |=> $stable(cmd_q));

endmodule

// File: tb/wide_lane_ctl_test.sv
module wide_lane_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_sense_n = 1'b1;
  logic        xfer_go = 1'b0;
  logic [3:0]  xfer_cmd = '0;
  logic [63:0] xfer_addr = '0, xfer_data = '0;
  logic [7:0]  xfer_be = '0;
  logic        wack_n = 1'b1;
  logic        xfer_busy, wreq_n, addr_phase, data_phase, ad_hi_oe, par_hi, par_hi_oe;
  logic [31:0] ad_lo, ad_hi;
  logic [3:0]  cbe_lo_n, cbe_hi_n;

  int checks = 0, failures = 0;
  logic slot_wide;
  logic prev_oe, prev_par;

  always #2.5 clk = ~clk;

  wide_lane_ctl uut (
    .clk(clk), .rst_n(rst_n), .wide_sense_n(wide_sense_n), .xfer_go(xfer_go),
    .xfer_cmd(xfer_cmd), .xfer_addr(xfer_addr), .xfer_data(xfer_data), .xfer_be(xfer_be),
    .xfer_busy(xfer_busy), .wack_n(wack_n), .wreq_n(wreq_n), .addr_phase(addr_phase),
    .data_phase(data_phase), .ad_lo(ad_lo), .ad_hi(ad_hi), .ad_hi_oe(ad_hi_oe),
    .cbe_lo_n(cbe_lo_n), .cbe_hi_n(cbe_hi_n), .par_hi(par_hi), .par_hi_oe(par_hi_oe));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input string t, input logic ea, input logic ed,
                      input logic [31:0] elo, input logic [31:0] ehi, input logic eoe,
                      input logic [3:0] ecl, input logic [3:0] ech, input logic ewq,
                      input logic ebusy);
    chk({t, " addr_phase"}, addr_phase, ea);
    chk({t, " data_phase"}, data_phase, ed);
    chk({t, " ad_lo"}, ad_lo, elo);
    chk({t, " ad_hi"}, ad_hi, ehi);
    chk({t, " R3 ad_hi_oe"}, ad_hi_oe, eoe);
    chk({t, " cbe_lo_n"}, cbe_lo_n, ecl);
    chk({t, " cbe_hi_n"}, cbe_hi_n, ech);
    chk({t, " R2 wreq_n"}, wreq_n, ewq);
    chk({t, " R9 xfer_busy"}, xfer_busy, ebusy);
    chk("R8 par_hi_oe", par_hi_oe, prev_oe);
    if (prev_oe) chk("R8 par_hi", par_hi, prev_par);
    prev_oe  = eoe;
    prev_par = ^{ehi, ech};
  endtask

  task automatic do_reset(input logic sense_n);
    @(negedge clk);
    rst_n = 1'b0;
    wide_sense_n = sense_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wide_sense_n = ~sense_n;
    slot_wide = ~sense_n;
    prev_oe = 1'b0;
    prev_par = 1'b0;
    @(negedge clk);
    look("R10 idle", 0, 0, 0, 0, 0, 4'hF, 4'hF, 1, 0);
  endtask

  task automatic xfer(input logic [3:0] cmd, input logic [63:0] addr,
                      input logic [63:0] data, input logic [7:0] be, input logic poke);
    logic mem, wide, hinz, ack;
    mem  = cmd == 4'h6 || cmd == 4'h7 || cmd == 4'hC || cmd == 4'hE || cmd == 4'hF;
    wide = slot_wide && mem;
    hinz = addr[63:32] != 0;
    ack  = ~wack_n;
    xfer_go = 1'b1; xfer_cmd = cmd; xfer_addr = addr; xfer_data = data; xfer_be = be;
    @(negedge clk);
    xfer_go = 1'b0;
    if (wide)
      look("R6 addr", 1, 0, addr[31:0], addr[63:32], 1, hinz ? ~4'hD : ~cmd, ~cmd, 0, 1);
    else
      look("R7 addr", 1, 0, addr[31:0], 0, 0, hinz ? ~4'hD : ~cmd, 4'hF, 1, 1);
    if (poke) begin
      xfer_go = 1'b1; xfer_cmd = 4'h2; xfer_addr = ~addr; xfer_data = ~data; xfer_be = ~be;
    end
    @(negedge clk);
    xfer_go = 1'b0;
    if (!wide && hinz) begin
      look("R7 addr2", 1, 0, addr[63:32], 0, 0, ~cmd, 4'hF, 1, 1);
      @(negedge clk);
    end
    if (wide && ack)
      look("R4 data", 0, 1, data[31:0], data[63:32], 1, ~be[3:0], ~be[7:4], 0, 1);
    else begin
      look("R5 data1", 0, 1, data[31:0], 0, 0, ~be[3:0], 4'hF, ~wide, 1);
      @(negedge clk);
      look("R5 data2", 0, 1, data[63:32], 0, 0, ~be[7:4], 4'hF, 1, 1);
    end
    @(negedge clk);
    look("R10 idle after", 0, 0, 0, 0, 0, 4'hF, 4'hF, 1, 0);
    @(negedge clk);
    look("R9 still idle", 0, 0, 0, 0, 0, 4'hF, 4'hF, 1, 0);
  endtask

  task automatic scen_narrow_slot;
    wack_n = 1'b0;
    do_reset(1'b1);
    xfer(4'h7, 64'h0000_0012_8000_0040, 64'hDEAD_BEEF_0123_4567, 8'hF0, 0); // R1 R7 R5
    xfer(4'h6, 64'h0000_0000_0000_1000, 64'h1111_2222_3333_4444, 8'h3C, 0); // R1
  endtask

  task automatic scen_wide_ack;
    wack_n = 1'b0;
    do_reset(1'b0);
    xfer(4'h7, 64'hABCD_0001_2000_0000, 64'hFFFF_0000_A5A5_5A5A, 8'hC3, 0); // R6 R4 R8
    xfer(4'hE, 64'h0000_0000_0000_2000, 64'h0F0F_0F0F_F0F0_F0F0, 8'hFF, 1); // R9
    xfer(4'h3, 64'h0000_0001_0000_0010, 64'h1234_5678_9ABC_DEF0, 8'h81, 0); // R2
  endtask

  task automatic scen_wide_noack;
    wack_n = 1'b1;
    do_reset(1'b0);
    xfer(4'hC, 64'h0000_00FF_0000_3000, 64'h7777_8888_9999_AAAA, 8'h5A, 0); // R3 R5
    xfer(4'h2, 64'h0000_0000_0000_0044, 64'h0000_0001_0000_0002, 8'h11, 0); // R2
  endtask

  initial begin
    scen_narrow_slot();
    scen_wide_ack();
    scen_wide_noack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule